// File: doc/BRIEF.md
# Dithered 14-bit PWM D/A generator

This block drives one pulse-width-modulated pin whose average duty over a frame of 16384 resolution ticks equals a 14-bit data value. A downstream RC filter turns the pin into an analog level. To keep the ripple frequency high, the frame is cut into short base cycles of fixed length. Each base cycle carries a coarse pulse whose width comes from the upper data bits. The lower data bits add one extra tick to a chosen subset of those base cycles. The subset is picked through a bit-reversed cycle index, which spreads the extra ticks evenly over the frame.

Two splits can be selected. The short split uses 256 base cycles of 64 ticks each. The long split uses 64 base cycles of 256 ticks each. The counter moves only on a resolution clock-enable. New data and split selection arrive over a valid/ready write port into a one-entry staging slot and take effect only at a frame boundary, so no frame mixes two settings. While the slot is occupied, ready is low and further writes are held back. A write that is presented while ready is low is not taken. The polarity pin applies at once and picks whether the active level is high or low.

Top module: `pwmd_gen`

## Requirements
- R1: The frame slot counter advances by one only in cycles with `tick` high and wraps from 16383 to 0; without `tick` the pin level does not change.
- R2: With split select 0, base cycle k = slot/64 and phase = slot mod 64; the base width is data[13:8] and the fine value is data[7:0].
- R3: With split select 1, base cycle k = slot/256 and phase = slot mod 256; the base width is data[13:6] and the fine value is data[5:0].
- R4: A slot is active when phase < width + e, where e = 1 if the bit-reversal of k (taken over the fine-field width) is less than the fine value, else 0; the level for slot s appears on the pin after the clock edge whose `tick` consumes slot s.
- R5: The number of active slots in each frame equals the 14-bit data value in force for that frame.
- R6: With `polarity` = 1 the pin is high in active slots and low otherwise; with `polarity` = 0 the pin is the inverse; a change of `polarity` shows on the pin in the same cycle.
- R7: `wr_ready` is high exactly when the staging slot is empty; a write is taken when `wr_valid` and `wr_ready` are both high at a clock edge, and it is moved into use at the tick that ends a frame (slot 16383), emptying the slot. A write taken in that same boundary cycle waits for the following boundary, and a write presented while `wr_ready` is low has no effect.
- R8: A data value of 0 keeps the pin at its inactive level for the whole frame; the value 16383 makes it active in all slots but one.
- R9: A synchronous reset sets the slot to 0, the data in use to 0 with split select 0, empties the staging slot, and drives the pin to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Resolution clock-enable, one tick per slot |
| wr_valid | input | 1 | Write request for data and split select |
| wr_ready | output | 1 | Staging slot is empty and can take a write |
| wr_data | input | 14 | Duty value to stage |
| wr_cfs | input | 1 | Split select to stage (0 short base cycle, 1 long) |
| polarity | input | 1 | 1 active-high output, 0 active-low output |
| pwm_out | output | 1 | PWM pin |

## Verification
The write handshake and the frame-boundary load can fall in the same cycle. When that happens, the write must land in the staging slot without being used for the frame that is just starting. The bench provokes this by presenting a write exactly on the tick that consumes slot 16383, with the tick enable otherwise random. It judges the outcome from the frame after: that frame must still carry the previous value, and only the frame after that may show the new value, both as a per-slot pattern and as an active-slot total. A second write offered while ready is low checks that a held-back write leaves the next frame's pattern untouched.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  localparam int unsigned PWMD_DATA_W  = 14;
  localparam int unsigned PWMD_FINE_W0 = 8;
  localparam int unsigned PWMD_FINE_W1 = 6;
  localparam int unsigned PWMD_SPLITS  = 2;
endpackage

// File: rtl/pwmd_frame_ctr.sv
module pwmd_frame_ctr #(
  parameter int unsigned DATA_W = pwmd_pkg::PWMD_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [DATA_W-1:0] slot,
  output logic              boundary
);
  localparam logic [DATA_W-1:0] SLOT_LAST = {DATA_W{1'b1}};

  logic [DATA_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (tick) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot     = slot_q;
  assign boundary = tick && (slot_q == SLOT_LAST);
endmodule

// File: rtl/pwmd_stage.sv
module pwmd_stage #(
  parameter int unsigned DATA_W = pwmd_pkg::PWMD_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cfs,
  output logic [DATA_W-1:0] cur_data,
  output logic              cur_split
);
  logic              full_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              pend_split_q;
  logic [DATA_W-1:0] cur_data_q;
  logic              cur_split_q;
  logic              accept;

  assign wr_ready = !full_q;
  assign accept   = wr_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q       <= 1'b0;
      pend_data_q  <= '0;
      pend_split_q <= 1'b0;
      cur_data_q   <= '0;
      cur_split_q  <= 1'b0;
    end else begin
      if (boundary && full_q) begin
        cur_data_q  <= pend_data_q;
        cur_split_q <= pend_split_q;
        full_q      <= 1'b0;
      end
      if (accept) begin
        pend_data_q  <= wr_data;
        pend_split_q <= wr_cfs;
        full_q       <= 1'b1;
      end
    end
  end

  assign cur_data  = cur_data_q;
  assign cur_split = cur_split_q;
endmodule

// File: rtl/pwmd_split.sv
module pwmd_split #(
  parameter int unsigned DATA_W = pwmd_pkg::PWMD_DATA_W,
  parameter int unsigned FINE_W = pwmd_pkg::PWMD_FINE_W0
) (
  input  logic [DATA_W-1:0] slot,
  input  logic [DATA_W-1:0] data,
  output logic              active
);
  localparam int unsigned PH_W = DATA_W - FINE_W;

  logic [FINE_W-1:0] cyc_idx;
  logic [FINE_W-1:0] cyc_rev;
  logic [FINE_W-1:0] fine;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   base_w;
  logic              extra;
  logic [PH_W:0]     limit;

  assign cyc_idx = slot[DATA_W-1 -: FINE_W];
  assign phase   = slot[PH_W-1:0];
  assign base_w  = data[DATA_W-1 -: PH_W];
  assign fine    = data[FINE_W-1:0];

  for (genvar i = 0; i < FINE_W; i++) begin : g_rev
    assign cyc_rev[i] = cyc_idx[FINE_W-1-i];
  end

  assign extra  = (cyc_rev < fine);
  assign limit  = {1'b0, base_w} + {{PH_W{1'b0}}, extra};
  assign active = ({1'b0, phase} < limit);
endmodule

// File: rtl/pwmd_gen.sv
module pwmd_gen #(
  parameter int unsigned DATA_W  = pwmd_pkg::PWMD_DATA_W,
  parameter int unsigned FINE_W0 = pwmd_pkg::PWMD_FINE_W0,
  parameter int unsigned FINE_W1 = pwmd_pkg::PWMD_FINE_W1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cfs,
  input  logic              polarity,
  output logic              pwm_out
);
  localparam int unsigned SPLITS = pwmd_pkg::PWMD_SPLITS;

  logic [DATA_W-1:0] slot;
  logic              boundary;
  logic [DATA_W-1:0] cur_data;
  logic              cur_split;
  logic [SPLITS-1:0] split_act;
  logic              act_q;

  pwmd_frame_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .slot     (slot),
    .boundary (boundary)
  );

  pwmd_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .wr_cfs    (wr_cfs),
    .cur_data  (cur_data),
    .cur_split (cur_split)
  );

  for (genvar m = 0; m < SPLITS; m++) begin : g_split
    localparam int unsigned FW = (m == 0) ? FINE_W0 : FINE_W1;
    pwmd_split #(.DATA_W(DATA_W), .FINE_W(FW)) u_dec (
      .slot   (slot),
      .data   (cur_data),
      .active (split_act[m])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
    end else if (tick) begin
      act_q <= split_act[cur_split];
    end
  end

  assign pwm_out = polarity ? act_q : !act_q;
endmodule

// File: rtl/pwmd_chk.sv
module pwmd_chk #(
  parameter int unsigned DATA_W = pwmd_pkg::PWMD_DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              act_q,
  input logic [DATA_W-1:0] slot,
  input logic [DATA_W-1:0] cur_data
);
  localparam logic [DATA_W-1:0] SLOT_LAST = {DATA_W{1'b1}};

  // R7
  stage_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R7
  stage_free_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (slot == SLOT_LAST) && !wr_ready) |=> wr_ready);

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(slot) && $stable(act_q));

  // R8
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cur_data == '0)) |=> !act_q);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!act_q && wr_ready && (slot == '0)));
endmodule

bind pwmd_gen pwmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .act_q    (act_q),
  .slot     (slot),
  .cur_data (cur_data)
);

// File: tb/tb_pwmd_gen.sv
module tb_pwmd_gen;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 16384;
  localparam int DMAX       = 16383;
  localparam int NFRAMES    = 7;
  localparam int WDOG       = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [13:0] wr_data = '0;
  logic        wr_cfs = 1'b0;
  logic        polarity = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int b_d, b_slot, b_pd, b_sum, pat_mis, rdy_mis;
  bit b_c, b_pc, b_full, b_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmd_gen dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_cfs(wr_cfs), .polarity(polarity), .pwm_out(pwm_out)
  );

  function automatic bit exp_act(int d, bit c, int s);
    int blen = c ? 256 : 64;
    int ncyc = c ? 64 : 256;
    int fbits = c ? 6 : 8;
    int k = s / blen;
    int ph = s % blen;
    int w = d / ncyc;
    int f = d % ncyc;
    int r = 0;
    for (int i = 0; i < fbits; i++)
      if (((k >> i) & 1) != 0) r = r | (1 << (fbits - 1 - i));
    return ph < (w + ((r < f) ? 1 : 0));
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic frame_end(bit gated);
    check(b_c ? "R3,R4 slot pattern (long split)" : "R2,R4 slot pattern (short split)", pat_mis, 0);
    check("R5 active slots per frame", b_sum, b_d);
    check("R7 ready vs staging state", rdy_mis, 0);
    if (b_d == 0) check("R8 zero value idle frame", b_sum, 0);
    if (b_d == DMAX) check("R8 max value frame", FRAME - b_sum, 1);
    if (gated) check("R1 gated tick frame pattern", pat_mis, 0);
    pat_mis = 0; rdy_mis = 0; b_sum = 0;
  endtask

  task automatic step(bit t, bit v, int d, bit c, bit gated);
    bit acc;
    bit a;
    tick = t; wr_valid = v; wr_data = 14'(d); wr_cfs = c;
    #1;
    if (wr_ready !== !b_full) rdy_mis++;
    acc = v && !b_full;
    @(posedge clk);
    @(negedge clk);
    if (t) begin
      a = exp_act(b_d, b_c, b_slot);
      b_last = a;
      if (a) b_sum++;
    end
    if (pwm_out !== (polarity ? b_last : !b_last)) pat_mis++;
    if (t && b_slot == FRAME - 1) begin
      frame_end(gated);
      if (b_full) begin b_d = b_pd; b_c = b_pc; b_full = 0; end
    end
    if (acc) begin b_pd = d; b_pc = c; b_full = 1; end
    if (t) b_slot = (b_slot + 1) % FRAME;
    tick = 0; wr_valid = 0;
  endtask

  initial begin
    int wd [NFRAMES];
    bit wc [NFRAMES];
    int ws [NFRAMES];
    void'($urandom(32'd7331));
    wd[0] = DMAX; wc[0] = 1; ws[0] = 1200;
    wd[1] = DMAX; wc[1] = 0; ws[1] = 9000;
    wd[2] = int'($urandom_range(1, DMAX - 1)); wc[2] = 0; ws[2] = 4000;
    wd[3] = int'($urandom_range(1, DMAX - 1)); wc[3] = 1; ws[3] = 300;
    wd[4] = int'($urandom_range(1, DMAX - 1)); wc[4] = 1; ws[4] = FRAME - 1;
    wd[5] = 0; wc[5] = 0; ws[5] = -1;
    wd[6] = 0; wc[6] = 0; ws[6] = -1;
    b_d = 0; b_c = 0; b_slot = 0; b_full = 0; b_pd = 0; b_pc = 0;
    b_sum = 0; pat_mis = 0; rdy_mis = 0; b_last = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R9 reset pin inactive", int'(pwm_out), 1);
    check("R9 reset ready", int'(wr_ready), 1);

    for (int f = 0; f < NFRAMES; f++) begin
      bit gated = (f == 4);
      bit wrote = 0;
      bit tried = 0;
      if (f == 4) begin
        polarity = 1;
        #1;
        check("R6 polarity change same cycle", int'(pwm_out), int'(b_last));
        polarity = 0;
        #1;
        check("R6 polarity restore", int'(pwm_out), int'(!b_last));
        polarity = 1;
      end
      if (f == 5) polarity = 0;
      while (1) begin
        bit t = gated ? bit'($urandom_range(0, 1)) : 1'b1;
        bit v = 0;
        int d = 0;
        bit c = 0;
        bit last;
        if (!wrote && ws[f] >= 0 && b_slot == ws[f]) begin
          v = 1; d = wd[f]; c = wc[f]; t = 1; wrote = 1;
        end else if (wrote && !tried && ws[f] < 16000 && b_slot == ws[f] + 5) begin
          v = 1; d = 14'h1555; c = !wc[f]; tried = 1;
          #1;
          check("R7 ready low while staged", int'(wr_ready), 0);
        end
        last = t && (b_slot == FRAME - 1);
        step(t, v, d, c, gated);
        if (last) break;
      end
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule